// File: doc/BRIEF.md
# Fetch/Store Memory Subsystem Controller

This block puts a word-addressed storage array behind an address holding register (MAR) and a data holding register (MDR). A requester asks for a fetch or a store with a request strobe, a single operation-select bit, an address and, for a store, a write word. The block then walks through the register transfers for that operation, one per clock, and raises a one-cycle done pulse at the end.

The cell to touch is always picked by a decoder that looks only at the MAR, in a decode step of its own, never straight from the address pins. After a fetch the word read stays in the MDR until the next operation overwrites it. An address at or above the configured depth raises an error flag and leaves the array untouched. Only one request is handled at a time; requests arriving while the block is busy are dropped.

Top module: `xm_ctrl`

## Requirements
- R1: While rst_ni is low and after it rises with no request, mar_o and mdr_o read 0 and busy_o, done_o and err_o are 0.
- R2: A fetch (req_i=1 with op_store_i=0 while busy_o=0) loads addr_i into mar_o at the accepting edge; done_o pulses in the third cycle after that edge and mdr_o then holds the word stored at that address.
- R3: A store (req_i=1 with op_store_i=1 while busy_o=0) loads mar_o at the accepting edge and wdata_i into mdr_o one edge later; done_o pulses in the fourth cycle after the accepting edge and a later fetch of that address returns the stored word.
- R4: op_store_i sampled with the accepted request alone chooses the sequence: 1 runs the store sequence, 0 runs the fetch sequence.
- R5: The cell accessed is set by mar_o only; changing addr_i or wdata_i after the accepting edge does not change the cell accessed or the word written.
- R6: A request seen while busy_o=1 is ignored: mar_o does not change, no extra done pulse follows and memory is not written.
- R7: busy_o is high from the cycle after the accepting edge through the done cycle, and done_o is high for exactly one cycle per accepted request.
- R8: mdr_o keeps its value while no operation runs, until the next accepted operation writes it.
- R9: An address greater than or equal to DEPTH (default 48) makes err_o high in the done cycle, holding until the next accepted request; a store then leaves every cell unchanged and a fetch leaves mdr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, taken when busy_o is low |
| op_store_i | input | 1 | Operation select: 1 store, 0 fetch |
| addr_i | input | ADDR_W | Word address of the request |
| wdata_i | input | DATA_W | Word to write on a store |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 1 | Address out of range for the last operation |
| mar_o | output | ADDR_W | Memory address register |
| mdr_o | output | DATA_W | Memory data register |

## Verification
The assertions assume that the decoder sees a settled MAR, which holds because the MAR only loads in the idle state, and that a request is only acted on from idle. They also take for granted that req_i is a plain level sampled at the clock; the bench drives every input on the falling edge, keeps operations back to back only after busy_o has dropped, and deliberately scrambles addr_i and wdata_i and raises req_i during busy cycles to probe that these are ignored.

// File: rtl/xm_pkg.sv
package xm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_MDR_LD = 3'd1,
    ST_DECODE = 3'd2,
    ST_READ   = 3'd3,
    ST_WRITE  = 3'd4,
    ST_DONE   = 3'd5
  } xm_state_e;
endpackage

// File: rtl/xm_seq.sv
module xm_seq
  import xm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic op_store_i,
  output logic busy_o,
  output logic done_o,
  output logic mar_ld_o,
  output logic mdr_ld_o,
  output logic dec_en_o,
  output logic rd_en_o,
  output logic wr_en_o
);
  xm_state_e state_q, state_d;
  logic      store_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = op_store_i ? ST_MDR_LD : ST_DECODE;
      ST_MDR_LD: state_d = ST_DECODE;
      ST_DECODE: state_d = store_q ? ST_WRITE : ST_READ;
      ST_READ:   state_d = ST_DONE;
      ST_WRITE:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      store_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (mar_ld_o) store_q <= op_store_i;
    end
  end

  assign mar_ld_o = (state_q == ST_IDLE) && req_i;
  assign mdr_ld_o = (state_q == ST_MDR_LD);
  assign dec_en_o = (state_q == ST_DECODE);
  assign rd_en_o  = (state_q == ST_READ);
  assign wr_en_o  = (state_q == ST_WRITE);
  assign done_o   = (state_q == ST_DONE);
  assign busy_o   = (state_q != ST_IDLE);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R6
  no_reaccept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mar_ld_o);
endmodule

// File: rtl/xm_decode.sv
module xm_decode #(
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 48
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DEPTH-1:0]  sel_o,
  output logic              hit_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    assign sel_o[i] = (addr_i == ADDR_W'(i));
  end
  assign hit_o = |sel_o;
endmodule

// File: rtl/xm_array.sv
module xm_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 48
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [DEPTH-1:0]  sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (wr_en_i && sel_i[i]) mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel_i[i]) rdata_o = rdata_o | mem_q[i];
    end
  end
endmodule

// File: rtl/xm_ctrl.sv
module xm_ctrl #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int DEPTH  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              op_store_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] mar_o,
  output logic [DATA_W-1:0] mdr_o
);
  logic              mar_ld, mdr_ld, dec_en, rd_en, wr_en;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mdr_q, wbuf_q, rdata;
  logic [DEPTH-1:0]  dec_sel, sel_q;
  logic              dec_hit, err_q;

  xm_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .op_store_i (op_store_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mar_ld_o   (mar_ld),
    .mdr_ld_o   (mdr_ld),
    .dec_en_o   (dec_en),
    .rd_en_o    (rd_en),
    .wr_en_o    (wr_en)
  );

  // Decoder sees the MAR only
  xm_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_dec (
    .addr_i (mar_q),
    .sel_o  (dec_sel),
    .hit_o  (dec_hit)
  );

  xm_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .wr_en_i (wr_en && !err_q),
    .sel_i   (sel_q),
    .wdata_i (mdr_q),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q  <= '0;
      mdr_q  <= '0;
      wbuf_q <= '0;
      sel_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (mar_ld) begin
        mar_q  <= addr_i;
        wbuf_q <= wdata_i;
        sel_q  <= '0;
        err_q  <= 1'b0;
      end else if (dec_en) begin
        sel_q  <= dec_sel;
        err_q  <= !dec_hit;
      end
      if (mdr_ld)                mdr_q <= wbuf_q;
      else if (rd_en && !err_q)  mdr_q <= rdata;
    end
  end

  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign err_o = err_q;

  // R5
  mar_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mar_q));
  // R8
  mdr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_i) |=> $stable(mdr_q));
  // R9
  err_nosel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (sel_q == '0));
  // R2
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_q));
  // R9
  err_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && err_q) |=> $stable(mdr_q));
endmodule

// File: tb/xm_ctrl_tb.sv
module xm_ctrl_tb;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEP = 48;

  typedef struct packed {
    logic          st;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          exp_err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd0,  16'h1111, 1'b0},
    '{1'b1, 6'd47, 16'hBEEF, 1'b0},
    '{1'b1, 6'd13, 16'h5A5A, 1'b0},
    '{1'b1, 6'd48, 16'h7777, 1'b1},
    '{1'b1, 6'd63, 16'h0F0F, 1'b1},
    '{1'b0, 6'd13, 16'h0000, 1'b0},
    '{1'b0, 6'd0,  16'h0000, 1'b0},
    '{1'b0, 6'd47, 16'h0000, 1'b0},
    '{1'b0, 6'd48, 16'h0000, 1'b1},
    '{1'b1, 6'd13, 16'h0001, 1'b0},
    '{1'b0, 6'd13, 16'h0000, 1'b0},
    '{1'b0, 6'd63, 16'h0000, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, op_st = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          busy, done, err;
  logic [AW-1:0] mar;
  logic [DW-1:0] mdr;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] mem_m [64];
  logic [DW-1:0] mdr_m = '0;

  always #4 clk = ~clk;

  xm_ctrl #(.DATA_W(DW), .ADDR_W(AW), .DEPTH(DEP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_store_i(op_st),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done),
    .err_o(err), .mar_o(mar), .mdr_o(mdr)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  // Runs one operation; scrambles addr/wdata after acceptance (R5)
  task automatic do_op(input logic st, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output int cyc);
    @(negedge clk);
    while (busy) @(negedge clk);
    req = 1'b1; op_st = st; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; op_st = ~st; addr = ~a; wdata = ~d;
    chk(mar == a, "R2", "mar after accept", 32'(mar), 32'(a));
    cyc = 1;
    while (!done && cyc < 10) begin
      chk(busy == 1'b1, "R7", "busy during op", 32'(busy), 1);
      if (st && cyc == 2) chk(mdr == d, "R3", "mdr loaded", 32'(mdr), 32'(d));
      @(negedge clk);
      cyc++;
    end
    chk(busy == 1'b1, "R7", "busy in done cycle", 32'(busy), 1);
  endtask

  function automatic bit in_rng(input logic [AW-1:0] a);
    return int'(a) < DEP;
  endfunction

  task automatic model(input logic st, input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (st) begin
      mdr_m = d;
      if (in_rng(a)) mem_m[a] = d;
    end else if (in_rng(a)) begin
      mdr_m = mem_m[a];
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int c;
    repeat (2) @(negedge clk);
    // R1 during reset
    chk({mar, mdr, busy, done, err} == '0, "R1", "outputs in reset",
        32'({mar, mdr}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({mar, mdr, busy, done, err} == '0, "R1", "outputs after reset",
        32'({busy, done, err}), 0);

    // Vector table: R2 R3 R4 R9
    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].st, VECS[i].addr, VECS[i].data, c);
      model(VECS[i].st, VECS[i].addr, VECS[i].data);
      chk(c == (VECS[i].st ? 4 : 3), VECS[i].st ? "R3" : "R2", "done latency",
          32'(c), VECS[i].st ? 4 : 3);
      chk(err == VECS[i].exp_err, "R9", "err flag", 32'(err), 32'(VECS[i].exp_err));
      chk(mdr === mdr_m, "R4", "mdr after op", 32'(mdr), 32'(mdr_m));
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R7", "done one cycle",
          32'({done, busy}), 0);
      chk(err == VECS[i].exp_err, "R9", "err held", 32'(err), 32'(VECS[i].exp_err));
    end

    // R9 err clears on next accepted request
    do_op(1'b0, 6'd47, '0, c);
    model(1'b0, 6'd47, '0);
    chk(err == 1'b0, "R9", "err cleared", 32'(err), 0);
    chk(mdr === mdr_m, "R2", "fetch 47", 32'(mdr), 32'(mdr_m));

    // R8 MDR holds while idle
    repeat (5) @(negedge clk);
    chk(mdr === mdr_m, "R8", "mdr held idle", 32'(mdr), 32'(mdr_m));

    // R6 requests during busy ignored
    @(negedge clk);
    req = 1'b1; op_st = 1'b1; addr = 6'd5; wdata = 16'hA5A5;
    @(negedge clk);
    op_st = 1'b1; addr = 6'd0; wdata = 16'hDEAD;
    @(negedge clk);
    addr = 6'd47; op_st = 1'b0;
    @(negedge clk);
    req = 1'b0;
    chk(mar == 6'd5, "R6", "mar kept while busy", 32'(mar), 5);
    c = 0;
    while (!done && c < 10) begin @(negedge clk); c++; end
    chk(done == 1'b1, "R6", "done reached", 32'(done), 1);
    model(1'b1, 6'd5, 16'hA5A5);
    chk(mdr == 16'hA5A5, "R5", "wbuf from accept", 32'(mdr), 32'hA5A5);
    @(negedge clk);
    repeat (3) begin
      chk(done == 1'b0 && busy == 1'b0, "R6", "no extra op", 32'({done, busy}), 0);
      @(negedge clk);
    end
    do_op(1'b0, 6'd0, '0, c);
    model(1'b0, 6'd0, '0);
    chk(mdr === mdr_m, "R6", "cell 0 untouched", 32'(mdr), 32'(mdr_m));
    do_op(1'b0, 6'd5, '0, c);
    model(1'b0, 6'd5, '0);
    chk(mdr == 16'hA5A5, "R5", "cell 5 written", 32'(mdr), 32'hA5A5);

    // R1 reset mid-operation
    @(negedge clk);
    req = 1'b1; op_st = 1'b1; addr = 6'd9; wdata = 16'h1234;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk({mar, mdr, busy, done, err} == '0, "R1", "reset mid-op",
        32'({mar, busy}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "idle after reset", 32'(busy), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule